// File: doc/BRIEF.md
# SRAM Cycle Controller

This block sits between a simple synchronous host port and an asynchronous static memory of 256 words by 4 bits. The host presents one request at a time: a valid flag, a write flag, an address and write data. The controller drives the memory pins and holds each phase for a whole number of clocks. Every phase length is the ceiling of a nanosecond minimum divided by the clock period. Both the clock period and the minimums are parameters.

A read places the address, waits out the address setup, then enables the chip with the output driver on. It samples the memory output only after the full access time has passed. A write raises the output disable first and drives the data and address. It then opens the write strobe for the required width, and holds address and data through the recovery time. The cycle is stretched when needed so that it meets the minimum write cycle length. When a cycle finishes, the host sees ready again and a one-clock done pulse. Read data is presented with that pulse.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted: ready is 1, done is 0, chip select (active low) is 1, write strobe (active low) is 1, output disable is 1 and the write-data drive enable is 0.
- R2: A request is accepted on a clock edge where valid and ready are both 1. Ready is 0 from the next cycle until the cycle ends. Requests presented while ready is 0 are ignored and write nothing.
- R3: With phase lengths S = max(1, ceil(20 ns / T)) and A = max(1, ceil(450 ns / T)), a read keeps chip select high for S cycles after acceptance. It then keeps chip select and output disable low for A cycles. The data is sampled, and done rises, on the (S+A)-th clock edge after the accepting edge.
- R4: The read data shown with done equals the last word written to that address, and it stays unchanged until the next read completes.
- R5: Before the write strobe falls, address and output disable have been stable and high for at least max(20, 130, 130) ns. That is W = max(1, ceil(max(20,130,130) ns / T)) cycles.
- R6: The write strobe, with chip select, stays low for P = max(1, ceil(250 ns / T)) cycles. Write data has been driven and stable for at least 250 ns when the strobe rises.
- R7: After the strobe rises, address and data stay driven for Q = max(ceil(50 ns / T), ceil(450 ns / T) − W − P, 1) cycles. Done rises on the (W+P+Q)-th edge after acceptance.
- R8: Done is high for exactly one cycle per completed request.
- R9: Output disable is low only while chip select is low during a read. The write strobe is never low while output disable is low.
- R10: The write-data drive enable is 1 only during a write cycle, and the write data stays constant while it is 1.
- R11: The memory address equals the accepted request address from the cycle after acceptance until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Controller idle, able to accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_sel_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_od_hi | output | 1 | Memory output disable, high turns the memory driver off |
| mem_wdata | output | DATA_W | Data to the memory inputs |
| mem_wdata_en | output | 1 | Write data drive enable |
| mem_rdata | input | DATA_W | Data from the memory outputs |

## Verification
The in-line assertions check the pin relations on every cycle. The write strobe never falls without a long enough output-disable lead, and it is never narrower than P. Address and write data never move during a cycle, and done is never wider than one clock. Only the bench scenarios can show that read data is correct and that the latency counts match the ceiling formulas. The same holds for requests ignored while busy and for back-to-back cycles. A behavioural memory in the bench measures setup, hold, pulse width and access time in nanoseconds. It also returns corrupted data if the controller samples too early.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RD_SETUP,
      PH_RD_ACCESS,
      PH_WR_SETUP,
      PH_WR_STROBE,
      PH_WR_RECOV
   } phase_e;

   typedef struct packed {
      logic sel_n;
      logic we_n;
      logic od_hi;
      logic drive;
   } strobe_t;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic strobe_t pins_of(input phase_e ph);
      strobe_t s;
      s = '{sel_n: 1'b1, we_n: 1'b1, od_hi: 1'b1, drive: 1'b0};
      case (ph)
         PH_RD_ACCESS: begin
            s.sel_n = 1'b0;
            s.od_hi = 1'b0;
         end
         PH_WR_SETUP,
         PH_WR_RECOV:  s.drive = 1'b1;
         PH_WR_STROBE: begin
            s.sel_n = 1'b0;
            s.we_n  = 1'b0;
            s.drive = 1'b1;
         end
         default: ;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R7: phase lengths depend on a strict one-per-clock count down
   assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_bus_regs.sv
`timescale 1ns/1ps
module sram_bus_regs #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else if (accept) begin
         mem_addr  <= req_addr;
         mem_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data <= '0;
      else if (capture) rd_data <= mem_rdata;
   end

   // R4: returned data moves only on a capture
   assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable(rd_data));

endmodule

// File: rtl/sram_cycle_fsm.sv
`timescale 1ns/1ps
module sram_cycle_fsm
   import sram_ctl_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int LEN_AS  = 1,
   parameter int LEN_RC  = 23,
   parameter int LEN_WS  = 7,
   parameter int LEN_WP  = 13,
   parameter int LEN_WR  = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             expired,
   output logic             ready,
   output logic             accept,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             capture,
   output logic             done,
   output strobe_t          stb
);

   localparam logic [CNT_W-1:0] LD_AS = CNT_W'(LEN_AS - 1);
   localparam logic [CNT_W-1:0] LD_RC = CNT_W'(LEN_RC - 1);
   localparam logic [CNT_W-1:0] LD_WS = CNT_W'(LEN_WS - 1);
   localparam logic [CNT_W-1:0] LD_WP = CNT_W'(LEN_WP - 1);
   localparam logic [CNT_W-1:0] LD_WR = CNT_W'(LEN_WR - 1);

   phase_e phase_q, phase_d;
   logic   finish;

   always_comb begin
      phase_d  = phase_q;
      load     = 1'b0;
      load_val = '0;
      capture  = 1'b0;
      finish   = 1'b0;
      case (phase_q)
         PH_IDLE: if (req_valid) begin
            load = 1'b1;
            if (req_write) begin
               phase_d  = PH_WR_SETUP;
               load_val = LD_WS;
            end else begin
               phase_d  = PH_RD_SETUP;
               load_val = LD_AS;
            end
         end
         PH_RD_SETUP: if (expired) begin
            phase_d  = PH_RD_ACCESS;
            load     = 1'b1;
            load_val = LD_RC;
         end
         PH_RD_ACCESS: if (expired) begin
            phase_d = PH_IDLE;
            capture = 1'b1;
         end
         PH_WR_SETUP: if (expired) begin
            phase_d  = PH_WR_STROBE;
            load     = 1'b1;
            load_val = LD_WP;
         end
         PH_WR_STROBE: if (expired) begin
            phase_d  = PH_WR_RECOV;
            load     = 1'b1;
            load_val = LD_WR;
         end
         PH_WR_RECOV: if (expired) begin
            phase_d = PH_IDLE;
            finish  = 1'b1;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done    <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done    <= capture | finish;
      end
   end

   assign ready  = (phase_q == PH_IDLE);
   assign accept = ready & req_valid;

   generate
      if (OUT_REG) begin : g_pin_reg
         strobe_t stb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stb_q <= pins_of(PH_IDLE);
            else        stb_q <= pins_of(phase_d);
         end
         assign stb = stb_q;
      end else begin : g_pin_comb
         assign stb = pins_of(phase_q);
      end
   endgenerate

   // checker counters for pulse widths and leads
   logic [15:0] we_low_cnt, od_hi_cnt, after_rise_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low_cnt     <= '0;
         od_hi_cnt      <= '0;
         after_rise_cnt <= '0;
      end else begin
         we_low_cnt     <= stb.we_n ? '0 : (&we_low_cnt ? we_low_cnt : we_low_cnt + 1'b1);
         od_hi_cnt      <= !stb.od_hi ? '0 : (&od_hi_cnt ? od_hi_cnt : od_hi_cnt + 1'b1);
         after_rise_cnt <= !stb.we_n ? '0 : (&after_rise_cnt ? after_rise_cnt : after_rise_cnt + 1'b1);
      end
   end

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stb.we_n) |-> (we_low_cnt >= 16'(LEN_WP)));

   assert_od_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stb.we_n) |-> (od_hi_cnt >= 16'(LEN_WS)));

   assert_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stb.drive) |-> (after_rise_cnt >= 16'(LEN_WR)));

   assert_no_strobe_unless_od_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.we_n |-> stb.od_hi);

   assert_od_low_only_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.od_hi |-> (!stb.sel_n && stb.we_n && !stb.drive));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid) |=> !ready);

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 4,
   parameter int CLK_NS    = 20,
   parameter int T_AS_NS   = 20,
   parameter int T_RC_NS   = 450,
   parameter int T_AW_NS   = 130,
   parameter int T_ODS_NS  = 130,
   parameter int T_WP_NS   = 250,
   parameter int T_DW_NS   = 250,
   parameter int T_DH_NS   = 50,
   parameter int T_WR_NS   = 50,
   parameter int T_WC_NS   = 450,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_we_n,
   output logic              mem_od_hi,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wdata_en,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int C_AS  = ns_to_cyc(T_AS_NS,  CLK_NS);
   localparam int C_RC  = ns_to_cyc(T_RC_NS,  CLK_NS);
   localparam int C_AW  = ns_to_cyc(T_AW_NS,  CLK_NS);
   localparam int C_ODS = ns_to_cyc(T_ODS_NS, CLK_NS);
   localparam int C_WP  = ns_to_cyc(T_WP_NS,  CLK_NS);
   localparam int C_DW  = ns_to_cyc(T_DW_NS,  CLK_NS);
   localparam int C_DH  = ns_to_cyc(T_DH_NS,  CLK_NS);
   localparam int C_WR  = ns_to_cyc(T_WR_NS,  CLK_NS);
   localparam int C_WC  = ns_to_cyc(T_WC_NS,  CLK_NS);

   localparam int LEN_AS  = imax(C_AS, 1);
   localparam int LEN_RC  = imax(C_RC, 1);
   localparam int LEN_WS  = imax(imax(C_AS, C_AW), imax(C_ODS, 1));
   localparam int LEN_WP  = imax(imax(C_WP, C_DW), 1);
   localparam int LEN_WR  = imax(imax(C_DH, C_WR), imax(C_WC - LEN_WS - LEN_WP, 1));
   localparam int LEN_MAX = imax(imax(LEN_AS, LEN_RC), imax(imax(LEN_WS, LEN_WP), LEN_WR));
   localparam int CNT_W   = $clog2(LEN_MAX + 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("CLK_NS must be positive");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
      if (T_AS_NS < 0 || T_RC_NS < 0 || T_AW_NS < 0 || T_ODS_NS < 0 ||
          T_WP_NS < 0 || T_DW_NS < 0 || T_DH_NS < 0 || T_WR_NS < 0 ||
          T_WC_NS < 0) begin : g_bad_timing
         $error("timing minimums must not be negative");
      end
   endgenerate

   logic             accept, load, expired, capture;
   logic [CNT_W-1:0] load_val;
   strobe_t          stb;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   sram_cycle_fsm #(
      .CNT_W   (CNT_W),
      .LEN_AS  (LEN_AS),
      .LEN_RC  (LEN_RC),
      .LEN_WS  (LEN_WS),
      .LEN_WP  (LEN_WP),
      .LEN_WR  (LEN_WR),
      .OUT_REG (OUT_REG)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .expired   (expired),
      .ready     (req_ready),
      .accept    (accept),
      .load      (load),
      .load_val  (load_val),
      .capture   (capture),
      .done      (rsp_done),
      .stb       (stb)
   );

   sram_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .rd_data   (rsp_rdata)
   );

   assign mem_sel_n    = stb.sel_n;
   assign mem_we_n     = stb.we_n;
   assign mem_od_hi    = stb.od_hi;
   assign mem_wdata_en = stb.drive;

   // R11: address held while a cycle runs
   assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

   // R10: write data frozen while driven
   assert_wdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wdata_en && $past(mem_wdata_en)) |-> $stable(mem_wdata));

   // R10: drive only inside a busy cycle
   assert_drive_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wdata_en |-> !req_ready);

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_sram_cycle_ctrl;

   localparam int CLK_NS = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_write = 1'b0;
   logic [7:0] req_addr = '0;
   logic [3:0] req_wdata = '0;
   logic       req_ready, rsp_done;
   logic [3:0] rsp_rdata;
   logic [7:0] mem_addr;
   logic       mem_sel_n, mem_we_n, mem_od_hi, mem_wdata_en;
   logic [3:0] mem_wdata;
   logic [3:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   sram_cycle_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_we_n(mem_we_n),
      .mem_od_hi(mem_od_hi), .mem_wdata(mem_wdata),
      .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int cyc(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // expected latencies from the requirement formulas
   function automatic int exp_rd_lat();
      return mx(1, cyc(20)) + mx(1, cyc(450));
   endfunction
   function automatic int exp_wr_lat();
      int w, p, q;
      w = mx(1, cyc(130));
      p = mx(1, cyc(250));
      q = mx(mx(cyc(50), cyc(450) - w - p), 1);
      return w + p + q;
   endfunction

   // behavioural memory with timing checks
   logic [3:0] mdl [256];
   logic [3:0] expv [256];
   longint t_addr = 0, t_data = 0, t_sel = 0, t_od = 0, t_ws = 0, t_wr = -1000;
   logic   wr_act;
   assign wr_act = rst_n && !mem_sel_n && !mem_we_n;

   always @(mem_addr) begin
      if (rst_n && (longint'($time) - t_wr < 50))
         chk(1'b0, "R7", "address moved inside recovery", longint'($time) - t_wr, 50);
      t_addr = longint'($time);
   end
   always @(mem_wdata) t_data = longint'($time);
   always @(negedge mem_sel_n) t_sel = longint'($time);
   always @(posedge mem_od_hi) t_od = longint'($time);

   always @(posedge wr_act) begin
      t_ws = longint'($time);
      chk(mem_od_hi == 1'b1, "R9", "od at strobe fall", longint'(mem_od_hi), 1);
      chk(t_ws - t_od >= 130, "R5", "od lead ns", t_ws - t_od, 130);
      chk(t_ws - t_addr >= 130, "R5", "address lead ns", t_ws - t_addr, 130);
      chk(mem_wdata_en == 1'b1, "R10", "drive during strobe", longint'(mem_wdata_en), 1);
   end

   always @(negedge wr_act) begin
      chk(longint'($time) - t_ws >= 250, "R6", "strobe width ns", longint'($time) - t_ws, 250);
      chk(longint'($time) - t_data >= 250, "R6", "data setup ns", longint'($time) - t_data, 250);
      mdl[mem_addr] = mem_wdata;
      t_wr = longint'($time);
   end

   always @(negedge mem_wdata_en) begin
      if (rst_n) begin
         chk(longint'($time) - t_wr >= 50, "R7", "data hold ns", longint'($time) - t_wr, 50);
         chk(longint'($time) - t_addr >= 450, "R7", "write cycle ns", longint'($time) - t_addr, 450);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_od_hi)
            chk(!mem_sel_n && mem_we_n && !mem_wdata_en, "R9", "od low outside read",
                longint'({mem_sel_n, mem_we_n, mem_wdata_en}), 3'b010);
         if (!mem_sel_n && !mem_od_hi && mem_we_n &&
             (longint'($time) - t_addr >= 450) && (longint'($time) - t_sel >= 400))
            mem_rdata <= mdl[mem_addr];
         else
            mem_rdata <= ~mdl[mem_addr];
      end
   end

   // R8: done never lasts two cycles
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n && prev_done)
         chk(!rsp_done, "R8", "done width", longint'(rsp_done), 0);
      prev_done = rsp_done;
   end

   // one host request, started and finished at a falling edge
   task automatic do_op(input bit wr, input logic [7:0] a, input logic [3:0] d,
                        input bit intrude, output int lat);
      logic [7:0] a0;
      bit         moved;
      int         k;
      chk(req_ready == 1'b1, "R2", "ready before request", longint'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      k = 0; moved = 1'b0; a0 = a;
      forever begin
         @(negedge clk);
         if (k == 0) begin
            req_valid = 1'b0;
            chk(mem_addr == a, "R11", "address after accept", longint'(mem_addr), longint'(a));
            chk(req_ready == 1'b0, "R2", "ready after accept", longint'(req_ready), 0);
         end
         if (intrude && k == 3) begin
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = a ^ 8'h3c; req_wdata = ~d;
         end
         if (intrude && k == 6) begin
            req_valid = 1'b0;
            chk(req_ready == 1'b0, "R2", "ready while intruding", longint'(req_ready), 0);
         end
         if (rsp_done) break;
         if (mem_addr != a0) moved = 1'b1;
         k++;
         if (k > 1000) begin
            chk(1'b0, "R2", "request never completed", k, 0);
            break;
         end
      end
      req_valid = 1'b0;
      chk(!moved, "R11", "address moved during cycle", longint'(moved), 0);
      chk(req_ready == 1'b1, "R2", "ready with done", longint'(req_ready), 1);
      lat = k;
      if (wr) expv[a] = d;
   endtask

   task automatic do_write(input logic [7:0] a, input logic [3:0] d, input bit intrude);
      int lat;
      do_op(1'b1, a, d, intrude, lat);
      chk(lat == exp_wr_lat(), "R7", "write latency", lat, exp_wr_lat());
   endtask

   task automatic do_read(input logic [7:0] a);
      int lat;
      do_op(1'b0, a, 4'h0, 1'b0, lat);
      chk(lat == exp_rd_lat(), "R3", "read latency", lat, exp_rd_lat());
      chk(rsp_rdata == expv[a], "R4", "read data", longint'(rsp_rdata), longint'(expv[a]));
   endtask

   initial begin
      #(200000 * CLK_NS);
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         mdl[i]  = 4'h0;
         expv[i] = 4'h0;
      end
      void'($urandom(32'd9157));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "ready in reset", longint'(req_ready), 1);
      chk(rsp_done == 1'b0, "R1", "done in reset", longint'(rsp_done), 0);
      chk(mem_sel_n == 1'b1, "R1", "select in reset", longint'(mem_sel_n), 1);
      chk(mem_we_n == 1'b1, "R1", "strobe in reset", longint'(mem_we_n), 1);
      chk(mem_od_hi == 1'b1, "R1", "od in reset", longint'(mem_od_hi), 1);
      chk(mem_wdata_en == 1'b0, "R1", "drive in reset", longint'(mem_wdata_en), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners: lowest and highest address, back to back
      do_write(8'h00, 4'ha, 1'b0);
      do_read(8'h00);
      do_write(8'hff, 4'h5, 1'b0);
      do_read(8'hff);
      do_read(8'h00);
      // R2: request presented while busy must not write
      do_write(8'h10, 4'h3, 1'b1);
      do_read(8'h10);
      do_read(8'h10 ^ 8'h3c);
      // R4: data held after done until next read
      repeat (4) @(negedge clk);
      chk(rsp_rdata == expv[8'h10 ^ 8'h3c], "R4", "data held while idle",
          longint'(rsp_rdata), longint'(expv[8'h10 ^ 8'h3c]));

      // constrained random mix over a small address window
      for (int n = 0; n < 120; n++) begin
         logic [7:0] a;
         a = 8'($urandom % 12) + 8'hf0;
         if ($urandom % 2 == 0) do_write(a, 4'($urandom), 1'b0);
         else                   do_read(a);
         if ($urandom % 4 == 0) repeat ($urandom % 3 + 1) @(negedge clk);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule